// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog peripheral for a system-on-chip. Software programs it through a small word-addressed register port. The port has an address, a write strobe and write data, and it returns combinational read data.

The input clock first passes through an 8-bit programmable prescaler. A second stage then divides by a selectable power of two. Each tick from this chain moves a 16-bit down-counter one step. When the counter is at zero, the next tick reloads it from a reload register, and that same tick counts as an expiry. An expiry can raise a sticky level interrupt, a reset request pulse of fixed length, or both, and each action has its own enable bit. Software keeps the system alive by writing the counter before it runs out.

Word offsets: control at 0x0, reload at 0x4, live counter at 0x8, interrupt clear at 0xC. Control fields: bit 0 is reset-action enable, bit 2 is interrupt-action enable, bits 4:3 are the divider select, bit 5 is timer enable, and bits 15:8 are the prescaler value P.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x00008021, the reload and counter registers both read 0x00008000, and both the interrupt and the reset request are low.
- R2: Control keeps only bits 0, 2, 3, 4, 5 and 15:8, so a write of all ones reads back as 0x0000FF3D. Reload keeps only its low 16 bits. Offset 0xC always reads zero.
- R3: While enabled, one counter step occurs every (P+1)·2^(4+S) clocks, where S is control bits 4:3 (0→16, 1→32, 2→64, 3→128). The first step comes exactly one full period after the enable write.
- R4: Each step decrements a non-zero counter by one. A step taken at zero loads the reload value instead, and that step is an expiry.
- R5: A write to offset 0x8 loads the live counter directly, and it takes priority over a step in the same cycle.
- R6: An expiry with bit 0 set drives the reset request high for exactly 128 clocks, starting the cycle after the expiry step.
- R7: An expiry with bit 2 set raises the interrupt, which stays high until a write to 0xC with data bit 0 set. A write to 0xC with bit 0 clear has no effect.
- R8: With bit 5 clear the counter holds its value and no expiry happens. The prescaler and divider stay at zero, so a re-enable gives a full first period.
- R9: The actions are independent. With bit 0 clear no reset request is produced, and with bit 2 clear no interrupt is raised, even though the counter still reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that feeds the prescaler and all registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | Reset request pulse |

## Verification
A prescaler or divider that is off by one changes the step period. The counter register then shows the slip at the first step after enable, which is at most one period. To catch it, the bench reads the counter one clock before and one clock after each predicted step, across many prescaler and divider settings. A wrong pulse counter or a missed expiry shows on rst_req or irq in the cycle after the expiry step. The pulse length is checked at both its ends. Stale divider state after a disable shows as an early first step after the re-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRESC_W  = 8;
  localparam int SEL_W    = 2;
  localparam int BASE_LOG2 = 4;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [SEL_W-1:0]   div_sel;
    logic               enable;
    logic               irq_en;
    logic               rst_en;
  } wdog_ctrl_t;

  localparam logic [1:0] WORD_CTRL   = 2'd0;
  localparam logic [1:0] WORD_RELOAD = 2'd1;
  localparam logic [1:0] WORD_COUNT  = 2'd2;
  localparam logic [1:0] WORD_CLEAR  = 2'd3;

  localparam int BIT_RST_EN = 0;
  localparam int BIT_IRQ_EN = 2;
  localparam int BIT_SEL_LO = 3;
  localparam int BIT_ENABLE = 5;
  localparam int BIT_PRESC_LO = 8;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int P_W  = PRESC_W,
  parameter int S_W  = SEL_W,
  parameter int B_L2 = BASE_LOG2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [P_W-1:0] presc,
  input  logic [S_W-1:0] div_sel,
  output logic           tick
);
  localparam int MAX_L2 = B_L2 + (1 << S_W) - 1;
  localparam int DIV_W  = MAX_L2;

  logic [P_W-1:0]   pcnt_q, pcnt_d;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic [DIV_W-1:0] dlast;
  logic             stage1;

  always_comb begin
    dlast = DIV_W'((1 << (B_L2 + int'(div_sel))) - 1);
  end

  always_comb begin
    stage1 = enable && (pcnt_q >= presc);
    tick   = stage1 && (dcnt_q >= dlast);
    pcnt_d = pcnt_q;
    dcnt_d = dcnt_q;
    if (!enable) begin
      pcnt_d = '0;
      dcnt_d = '0;
    end else if (stage1) begin
      pcnt_d = '0;
      dcnt_d = tick ? '0 : dcnt_q + 1'b1;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      dcnt_q <= dcnt_d;
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = tick && at_zero && !load_we;
    cnt_d   = cnt_q;
    if (load_we)
      cnt_d = load_val;
    else if (tick)
      cnt_d = at_zero ? reload_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !load_we) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !load_we) |=> cnt_q == $past(reload_val));
  assert_keepalive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> cnt_q == $past(load_val));
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_we) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_action.sv
module wdog_action #(
  parameter int RST_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  input  logic irq_en,
  input  logic irq_clr,
  output logic rst_req,
  output logic irq
);
  localparam int LEFT_W = $clog2(RST_CYCLES + 1);

  logic [LEFT_W-1:0] left_q, left_d;
  logic              flag_q, flag_d;

  always_comb begin
    left_d = left_q;
    if (expire && rst_en)   left_d = LEFT_W'(RST_CYCLES);
    else if (left_q != '0)  left_d = left_q - 1'b1;
    flag_d = flag_q;
    if (expire && irq_en)   flag_d = 1'b1;
    else if (irq_clr)       flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      flag_q <= 1'b0;
    end else begin
      left_q <= left_d;
      flag_q <= flag_d;
    end
  end

  assign rst_req = (left_q != '0);
  assign irq     = flag_q;

  assert_rst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(expire && rst_en));
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1 << (CNT_W - 1));
  localparam wdog_ctrl_t CTRL_RST = '{presc: PRESC_W'(8'h80), div_sel: '0,
                                      enable: 1'b1, irq_en: 1'b0, rst_en: 1'b1};

  wdog_ctrl_t       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [1:0]       word;
  logic             wr_ctrl, wr_reload, wr_count, wr_clear;
  logic             tick, expire;
  logic [CNT_W-1:0] cnt;

  assign word      = bus_addr[3:2];
  assign wr_ctrl   = bus_we && (word == WORD_CTRL);
  assign wr_reload = bus_we && (word == WORD_RELOAD);
  assign wr_count  = bus_we && (word == WORD_COUNT);
  assign wr_clear  = bus_we && (word == WORD_CLEAR);

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (wr_ctrl) begin
      ctrl_d.rst_en  = bus_wdata[BIT_RST_EN];
      ctrl_d.irq_en  = bus_wdata[BIT_IRQ_EN];
      ctrl_d.enable  = bus_wdata[BIT_ENABLE];
      ctrl_d.div_sel = bus_wdata[BIT_SEL_LO +: SEL_W];
      ctrl_d.presc   = bus_wdata[BIT_PRESC_LO +: PRESC_W];
    end
    if (wr_reload) reload_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= CNT_RST;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      WORD_CTRL: begin
        bus_rdata[BIT_RST_EN] = ctrl_q.rst_en;
        bus_rdata[BIT_IRQ_EN] = ctrl_q.irq_en;
        bus_rdata[BIT_ENABLE] = ctrl_q.enable;
        bus_rdata[BIT_SEL_LO +: SEL_W]     = ctrl_q.div_sel;
        bus_rdata[BIT_PRESC_LO +: PRESC_W] = ctrl_q.presc;
      end
      WORD_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
      WORD_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
      default:     bus_rdata = '0;
    endcase
  end

  wdog_prescaler #(.P_W(PRESC_W), .S_W(SEL_W), .B_L2(BASE_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable),
    .presc(ctrl_q.presc), .div_sel(ctrl_q.div_sel), .tick(tick));

  wdog_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_count (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q.enable), .tick(tick),
    .load_we(wr_count), .load_val(bus_wdata[CNT_W-1:0]),
    .reload_val(reload_q), .cnt(cnt), .expire(expire));

  wdog_action #(.RST_CYCLES(RST_CYCLES)) u_act (
    .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(ctrl_q.rst_en),
    .irq_en(ctrl_q.irq_en), .irq_clr(wr_clear && bus_wdata[0]),
    .rst_req(rst_req), .irq(irq));

  assert_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_q.enable);
  assert_no_rst_without_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.rst_en && !rst_req) |=> !rst_req);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer i_wdog_timer (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t;
    bit saw_rst;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 32'h8021);
    rd(4'h4, v); chk("R1 reload", v, 32'h8000);
    rd(4'h8, v); chk("R1 count", v, 32'h8000);
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);

    // R2 masking
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 ctrl mask", v, 32'hFF3D);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hABCD_1234); rd(4'h4, v); chk("R2 reload mask", v, 32'h1234);
    rd(4'hC, v); chk("R2 clear reads zero", v, 32'h0);

    // R3/R4 period sweep
    foreach (v[i]) begin end
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      for (int s = 0; s < 4; s++) begin
        t = (p + 1) << (4 + s);
        wr(4'h0, (p << 8) | (s << 3));
        wr(4'h8, 100);
        wr(4'h0, (p << 8) | (s << 3) | 32'h20);
        edges(t - 1); rd(4'h8, v); chk($sformatf("R3 p%0d s%0d before", p, s), v, 100);
        edges(1);     rd(4'h8, v); chk($sformatf("R3 p%0d s%0d first", p, s), v, 99);
        edges(t - 1); rd(4'h8, v); chk($sformatf("R4 p%0d s%0d hold", p, s), v, 99);
        edges(1);     rd(4'h8, v); chk($sformatf("R4 p%0d s%0d second", p, s), v, 98);
      end
    end
    // R3 largest prescaler and divider
    t = 256 * 128;
    wr(4'h0, 32'hFF18); wr(4'h8, 7); wr(4'h0, 32'hFF38);
    edges(t - 1); rd(4'h8, v); chk("R3 max before", v, 7);
    edges(1);     rd(4'h8, v); chk("R3 max step", v, 6);

    // R6 reset pulse, R4 reload
    wr(4'h0, 32'h0); wr(4'h4, 20); wr(4'h8, 2); wr(4'h0, 32'h21);
    edges(3 * 16 - 1); chk("R6 low before expiry", rst_req, 0);
    edges(1); chk("R6 rises", rst_req, 1);
    rd(4'h8, v); chk("R4 reload at expiry", v, 20);
    chk("R9 no irq when disabled", irq, 0);
    edges(127); chk("R6 still high at 128", rst_req, 1);
    edges(1);   chk("R6 low after 128", rst_req, 0);
    wr(4'h0, 32'h0);

    // R7 sticky interrupt
    wr(4'h8, 1); wr(4'h0, 32'h24);
    edges(2 * 16 - 1); chk("R7 irq low before", irq, 0);
    edges(1); chk("R7 irq rises", irq, 1); chk("R9 no rst_req", rst_req, 0);
    wr(4'h0, 32'h04);
    edges(50); chk("R7 irq holds", irq, 1);
    wr(4'hC, 32'h0); chk("R7 clear with 0 ignored", irq, 1);
    edges(3); chk("R7 still held", irq, 1);
    wr(4'hC, 32'h1); chk("R7 cleared", irq, 0);

    // R8 frozen when disabled
    wr(4'h8, 9); wr(4'h0, 32'h01);
    edges(300); rd(4'h8, v); chk("R8 frozen", v, 9);
    chk("R8 no reset", rst_req, 0);
    // R8 clean restart
    wr(4'h8, 50); wr(4'h0, 32'h28);
    edges(20); wr(4'h0, 32'h08); edges(5);
    wr(4'h0, 32'h28);
    edges(31); rd(4'h8, v); chk("R8 full period before", v, 50);
    edges(1);  rd(4'h8, v); chk("R8 full period step", v, 49);

    // R9 no action with both enables clear
    wr(4'h0, 32'h0); wr(4'h8, 0); wr(4'h0, 32'h20);
    edges(16); rd(4'h8, v); chk("R9 reload without action", v, 20);
    edges(2); chk("R9 rst_req off", rst_req, 0); chk("R9 irq off", irq, 0);

    // R5 keep-alive
    wr(4'h0, 32'h0); wr(4'h8, 3); wr(4'h0, 32'h21);
    saw_rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < 40; c++) begin
        @(posedge clk); #1;
        if (rst_req) saw_rst = 1'b1;
      end
      wr(4'h8, 3); rd(4'h8, v);
      chk("R5 load direct", v, 3);
    end
    chk("R5 serviced, no reset", saw_rst, 0);
    wr(4'h0, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule